// File: doc/BRIEF.md
# Serial-Addressed Device Initialisation Register

This block holds the 16-bit initialisation control word of a memory device, together with the logic that acts on it. Register accesses arrive as already-decoded serial request packets. Each packet carries a 6-bit serial device address. The block acts on a packet only when that address equals its own stored device identifier. A matching read returns the whole word one cycle later.

The word has several jobs. It controls the serial chain repeater, which either passes the serial input through to the next device or parks the output high. It holds the nap and power-down self-refresh enables. Each of those enables is protected from being set while the device sits in the power state it governs. The word also decides how a nap or power-down exit is recognised: without an address, as a broadcast, or as a directed exit that must name this device. A disable bit makes the device deaf to all exits. When an exit applies, the block pulses a wake output so that the surrounding power controller can return the device to the active state.

Top module: `init_ctrl_reg`

## Requirements
- R1: A read or write request acts only when its 6-bit address equals the stored device identifier. A matching read raises `rdValid` with the word on `rdData` in the cycle after the request. A non-matching request changes nothing and gives no `rdValid`.
- R2: After reset (`rst_n` low), the identifier is 0x3F, the repeater bit is 1 and every other stored bit is 0, so a read at address 0x3F returns 0x809F.
- R3: The read word layout is as follows. Bit 15 holds identifier bit 5. Bit 14 holds interleave. Bit 13 holds disable. Bit 12 holds temperature output. Bit 11 holds temperature enable. Bit 10 holds low-power refresh. Bit 9 holds power-down refresh. Bit 8 holds nap refresh. Bit 7 holds repeater. Bit 6 holds exit select. Bit 5 always reads 0. Bits 4..0 hold identifier bits 4..0. A write uses the same positions, and a write to bit 5 or bit 12 has no effect.
- R4: With the repeater bit at 1, `sioOut` equals `sioIn`. With it at 0, `sioOut` is 1.
- R5: While `pwrState` is nap (2'b01), a write cannot change the nap refresh bit (bit 8) from 0 to 1, but it can clear it. In any other state the write takes effect. `napSelfRef` shows the bit.
- R6: While `pwrState` is power-down (2'b10), a write cannot change the power-down refresh bit (bit 9) from 0 to 1, but it can clear it. `pdnSelfRef` shows the bit.
- R7: An exit needs no address when exit select is 1. When exit select is 0, the exit applies if `exitAddr[5]` is 1 (broadcast), or if `exitAddr[4:0]` equals identifier bits 4..0 (directed).
- R8: While the disable bit is 1, no exit strobe raises `wake`.
- R9: `wake` is 1 for exactly the cycle after a one-cycle `exitStrobe` that applies, and only when `pwrState` is nap or power-down at the strobe. Active (2'b00) and reserved (2'b11) states never wake.
- R10: The temperature output bit reads as `tempTrip` when temperature enable is 1, and reads as 0 otherwise. `lowPwrRef` shows the low-power refresh bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Serial interface reset, active low |
| reqValid | input | 1 | Register request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Serial device address of the request |
| reqWdata | input | 16 | Write word |
| rdValid | output | 1 | Read data valid |
| rdData | output | 16 | Read word |
| sioIn | input | 1 | Serial chain input |
| sioOut | output | 1 | Serial chain repeater output |
| pwrState | input | 2 | 00 active, 01 nap, 10 power-down, 11 reserved |
| exitStrobe | input | 1 | Exit sequence seen |
| exitAddr | input | 6 | Address bits sent with an exit |
| tempTrip | input | 1 | Thermal trip indication |
| napSelfRef | output | 1 | Nap self-refresh enable |
| pdnSelfRef | output | 1 | Power-down self-refresh enable |
| lowPwrRef | output | 1 | Low-power self-refresh enable |
| wake | output | 1 | One-cycle exit-accepted pulse |

## Verification
The bench builds the block with its default parameters: reset identifier 0x3F and a combinational repeater path. The default identifier makes the reset-state read and the first reprogramming of the identifier reachable. The combinational repeater lets the pin check follow `sioIn` in the same cycle. Together these defaults reach the re-addressing path, in which the old address goes dead, and the sequences through all four power states that exercise the refresh locks and the three exit addressing modes.

// File: rtl/init_ctrl_pkg.sv
package init_ctrl_pkg;
  localparam int ID_W  = 6;
  localparam int REG_W = 16;

  localparam int B_IDHI = 15;
  localparam int B_ILV  = 14;
  localparam int B_DIS  = 13;
  localparam int B_TSQ  = 12;
  localparam int B_TEN  = 11;
  localparam int B_LSR  = 10;
  localparam int B_PSR  = 9;
  localparam int B_NSR  = 8;
  localparam int B_RPT  = 7;
  localparam int B_PSX  = 6;
  localparam int B_ZERO = 5;
  localparam int ID_LO_W = ID_W - 1;

  typedef enum logic [1:0] {
    PWR_ACTIVE = 2'b00,
    PWR_NAP    = 2'b01,
    PWR_DOWN   = 2'b10,
    PWR_RSVD   = 2'b11
  } pwr_e;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic lockNap;
    logic lockDown;
  } ctlStb_t;
endpackage

// File: rtl/init_ctrl_ctl.sv
module init_ctrl_ctl
  import init_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [ID_W-1:0] reqAddr,
  input  logic [ID_W-1:0] devId,
  input  logic [1:0]      pwrState,
  input  logic            exitStrobe,
  input  logic [ID_W-1:0] exitAddr,
  input  logic            exitSel,
  input  logic            devDisable,
  output ctlStb_t         stb,
  output logic            wake
);
  logic addrHit;
  logic lowPower;
  logic exitBcast;
  logic exitMatch;
  logic exitHit;
  logic wakeNext;

  assign addrHit = (reqAddr == devId);

  always_comb begin
    stb.wrEn     = reqValid &  reqWrite & addrHit;
    stb.rdEn     = reqValid & ~reqWrite & addrHit;
    stb.lockNap  = (pwrState == PWR_NAP);
    stb.lockDown = (pwrState == PWR_DOWN);
  end

  assign lowPower  = (pwrState == PWR_NAP) | (pwrState == PWR_DOWN);
  assign exitBcast = exitAddr[ID_W-1];
  assign exitMatch = (exitAddr[ID_LO_W-1:0] == devId[ID_LO_W-1:0]);
  assign exitHit   = exitSel | exitBcast | exitMatch;
  assign wakeNext  = exitStrobe & lowPower & ~devDisable & exitHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= wakeNext;
  end

  AST_DISABLED_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    devDisable |=> !wake); // R8
  AST_WAKE_NEEDS_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
    (!lowPower || !exitStrobe) |=> !wake); // R9
endmodule

// File: rtl/init_ctrl_dp.sv
module init_ctrl_dp
  import init_ctrl_pkg::*;
#(
  parameter logic [ID_W-1:0] RESET_ID = 6'h3F,
  parameter bit              RPT_FLOP = 1'b0
)(
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStb_t          stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             tempTrip,
  input  logic             sioIn,
  output logic             sioOut,
  output logic             rdValid,
  output logic [REG_W-1:0] rdData,
  output logic [ID_W-1:0]  devId,
  output logic             exitSel,
  output logic             devDisable,
  output logic             napSelfRef,
  output logic             pdnSelfRef,
  output logic             lowPwrRef,
  output logic [REG_W-1:0] regWord
);
  logic [ID_W-1:0] idReg;
  logic ilvReg, disReg, tenReg, lsrReg, psrReg, nsrReg, rptReg, psxReg;
  logic tsq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idReg  <= RESET_ID;
      ilvReg <= 1'b0;
      disReg <= 1'b0;
      tenReg <= 1'b0;
      lsrReg <= 1'b0;
      psrReg <= 1'b0;
      nsrReg <= 1'b0;
      rptReg <= 1'b1;
      psxReg <= 1'b0;
    end else if (stb.wrEn) begin
      idReg  <= {wrData[B_IDHI], wrData[ID_LO_W-1:0]};
      ilvReg <= wrData[B_ILV];
      disReg <= wrData[B_DIS];
      tenReg <= wrData[B_TEN];
      lsrReg <= wrData[B_LSR];
      psrReg <= stb.lockDown ? (psrReg & wrData[B_PSR]) : wrData[B_PSR];
      nsrReg <= stb.lockNap  ? (nsrReg & wrData[B_NSR]) : wrData[B_NSR];
      rptReg <= wrData[B_RPT];
      psxReg <= wrData[B_PSX];
    end
  end

  assign tsq = tenReg & tempTrip;

  always_comb begin
    regWord                 = '0;
    regWord[B_IDHI]         = idReg[ID_W-1];
    regWord[B_ILV]          = ilvReg;
    regWord[B_DIS]          = disReg;
    regWord[B_TSQ]          = tsq;
    regWord[B_TEN]          = tenReg;
    regWord[B_LSR]          = lsrReg;
    regWord[B_PSR]          = psrReg;
    regWord[B_NSR]          = nsrReg;
    regWord[B_RPT]          = rptReg;
    regWord[B_PSX]          = psxReg;
    regWord[B_ZERO]         = 1'b0;
    regWord[ID_LO_W-1:0]    = idReg[ID_LO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= regWord;
    end
  end

  generate
    if (RPT_FLOP) begin : g_rptFlop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sioOut <= 1'b1;
        else        sioOut <= rptReg ? sioIn : 1'b1;
      end
    end else begin : g_rptComb
      assign sioOut = rptReg ? sioIn : 1'b1;
    end
  endgenerate

  assign devId      = idReg;
  assign exitSel    = psxReg;
  assign devDisable = disReg;
  assign napSelfRef = nsrReg;
  assign pdnSelfRef = psrReg;
  assign lowPwrRef  = lsrReg;

  AST_NAP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lockNap && !napSelfRef) |=> !napSelfRef); // R5
  AST_DOWN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.lockDown && !pdnSelfRef) |=> !pdnSelfRef); // R6
  AST_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> !rdData[B_ZERO]); // R3
endmodule

// File: rtl/init_ctrl_reg.sv
module init_ctrl_reg
  import init_ctrl_pkg::*;
#(
  parameter logic [5:0] RESET_ID = 6'h3F,
  parameter bit         RPT_FLOP = 1'b0
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [5:0]  reqAddr,
  input  logic [15:0] reqWdata,
  output logic        rdValid,
  output logic [15:0] rdData,
  input  logic        sioIn,
  output logic        sioOut,
  input  logic [1:0]  pwrState,
  input  logic        exitStrobe,
  input  logic [5:0]  exitAddr,
  input  logic        tempTrip,
  output logic        napSelfRef,
  output logic        pdnSelfRef,
  output logic        lowPwrRef,
  output logic        wake
);
  ctlStb_t          stb;
  logic [ID_W-1:0]  devId;
  logic             exitSel;
  logic             devDisable;
  logic [REG_W-1:0] regWord;
  logic [REG_W-1:0] tsqMask;

  assign tsqMask = ~(REG_W'(1) << B_TSQ);

  init_ctrl_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .devId(devId), .pwrState(pwrState),
    .exitStrobe(exitStrobe), .exitAddr(exitAddr), .exitSel(exitSel),
    .devDisable(devDisable), .stb(stb), .wake(wake)
  );

  init_ctrl_dp #(.RESET_ID(RESET_ID), .RPT_FLOP(RPT_FLOP)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(reqWdata),
    .tempTrip(tempTrip), .sioIn(sioIn), .sioOut(sioOut),
    .rdValid(rdValid), .rdData(rdData), .devId(devId), .exitSel(exitSel),
    .devDisable(devDisable), .napSelfRef(napSelfRef),
    .pdnSelfRef(pdnSelfRef), .lowPwrRef(lowPwrRef), .regWord(regWord)
  );

  AST_MISS_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr != devId) |=> $stable(regWord & tsqMask)); // R1
  AST_MISS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!reqValid || reqWrite || reqAddr != devId) |=> !rdValid); // R1
endmodule

// File: tb/init_ctrl_reg_test.sv
`timescale 1ns/1ps
module init_ctrl_reg_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [5:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic rdValid;
  logic [15:0] rdData;
  logic sioIn = 1'b0, sioOut;
  logic [1:0] pwrState = 2'b00;
  logic exitStrobe = 1'b0;
  logic [5:0] exitAddr = '0;
  logic tempTrip = 1'b0;
  logic napSelfRef, pdnSelfRef, lowPwrRef, wake;

  int nChecks = 0;
  int nErr = 0;

  typedef struct {string req; logic [15:0] val;} exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  init_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rdValid(rdValid), .rdData(rdData),
    .sioIn(sioIn), .sioOut(sioOut), .pwrState(pwrState),
    .exitStrobe(exitStrobe), .exitAddr(exitAddr), .tempTrip(tempTrip),
    .napSelfRef(napSelfRef), .pdnSelfRef(pdnSelfRef), .lowPwrRef(lowPwrRef),
    .wake(wake)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop expected read words as the design returns them
  always @(negedge clk) begin
    if (rst_n && rdValid) begin
      if (expQ.size() == 0) check("R1 unexpected rdValid", 16'd1, 16'd0);
      else begin
        exp_t e;
        e = expQ.pop_front();
        check(e.req, rdData, e.val);
      end
    end
  end

  task automatic doWrite(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doRead(logic [5:0] a, bit hit, logic [15:0] exp, string req);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    if (hit) expQ.push_back('{req, exp});
    @(negedge clk);
    reqValid = 1'b0;
    if (!hit) check(req, {15'd0, rdValid}, 16'd0);
  endtask

  task automatic doExit(logic [1:0] st, logic [5:0] a, bit expWake, string req);
    @(negedge clk);
    pwrState = st; exitAddr = a; exitStrobe = 1'b1;
    @(negedge clk);
    exitStrobe = 1'b0;
    check(req, {15'd0, wake}, {15'd0, expWake});
    @(negedge clk);
    check({req, " pulse end"}, {15'd0, wake}, 16'd0);
  endtask

  initial begin
    #100000;
    nChecks++; nErr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state, R4 repeater copies
    @(negedge clk);
    check("R2 napSelfRef", {15'd0, napSelfRef}, 16'd0);
    check("R2 pdnSelfRef", {15'd0, pdnSelfRef}, 16'd0);
    sioIn = 1'b1; #1;
    check("R4 repeater on copies 1", {15'd0, sioOut}, 16'd1);
    sioIn = 1'b0; #1;
    check("R4 repeater on copies 0", {15'd0, sioOut}, 16'd0);
    doRead(6'h3F, 1, 16'h809F, "R2 R3 reset word");

    // R1 re-address to 0x25, ten and lsr on, repeater off
    doWrite(6'h3F, 16'h8C05);
    doRead(6'h3F, 0, 16'h0, "R1 old address dead");
    doRead(6'h25, 1, 16'h8C05, "R1 R3 new word");
    check("R10 lowPwrRef", {15'd0, lowPwrRef}, 16'd1);
    @(negedge clk); sioIn = 1'b0; #1;
    check("R4 repeater off holds 1", {15'd0, sioOut}, 16'd1);
    tempTrip = 1'b1;
    doRead(6'h25, 1, 16'h9C05, "R10 trip visible with enable");
    doWrite(6'h3F, 16'hFFFF);
    doRead(6'h25, 1, 16'h9C05, "R1 miss write ignored");
    tempTrip = 1'b0;

    // R5 nap lock, R6 down lock
    @(negedge clk); pwrState = 2'b01;
    doWrite(6'h25, 16'h8F05);
    doRead(6'h25, 1, 16'h8E05, "R5 nap refresh blocked in nap");
    check("R5 napSelfRef pin", {15'd0, napSelfRef}, 16'd0);
    check("R6 pdnSelfRef set in nap", {15'd0, pdnSelfRef}, 16'd1);
    @(negedge clk); pwrState = 2'b10;
    doWrite(6'h25, 16'h8F05);
    doRead(6'h25, 1, 16'h8F05, "R5 nap refresh set outside nap");
    doWrite(6'h25, 16'h8D05);
    doRead(6'h25, 1, 16'h8D05, "R6 clear allowed in down");
    doWrite(6'h25, 16'h8F05);
    doRead(6'h25, 1, 16'h8D05, "R6 set blocked in down");
    check("R6 pdnSelfRef pin", {15'd0, pdnSelfRef}, 16'd0);
    @(negedge clk); pwrState = 2'b01;
    doWrite(6'h25, 16'h8C05);
    doRead(6'h25, 1, 16'h8C05, "R5 clear allowed in nap");

    // R7 R9 exit addressing, exit select 0
    doExit(2'b01, 6'h05, 1, "R7 directed match wakes");
    doExit(2'b01, 6'h06, 0, "R7 directed miss");
    doExit(2'b10, 6'h3A, 1, "R7 broadcast wakes");
    doExit(2'b00, 6'h05, 0, "R9 active never wakes");
    doExit(2'b11, 6'h05, 0, "R9 reserved never wakes");
    // exit select 1
    @(negedge clk); pwrState = 2'b00;
    doWrite(6'h25, 16'h8C45);
    doExit(2'b01, 6'h06, 1, "R7 no-address exit wakes");
    // R8 disable
    @(negedge clk); pwrState = 2'b00;
    doWrite(6'h25, 16'hAC45);
    doRead(6'h25, 1, 16'hAC45, "R3 disable bit position");
    doExit(2'b01, 6'h25, 0, "R8 disabled nap");
    doExit(2'b10, 6'h20, 0, "R8 disabled broadcast");

    // R3 interleave and zero bit, R4 repeater back on
    @(negedge clk); pwrState = 2'b00;
    doWrite(6'h25, 16'hCCE5);
    doRead(6'h25, 1, 16'hCCC5, "R3 interleave set, bit5 reads 0");
    @(negedge clk); sioIn = 1'b1; #1;
    check("R4 repeater restored", {15'd0, sioOut}, 16'd1);
    sioIn = 1'b0; #1;
    check("R4 repeater restored low", {15'd0, sioOut}, 16'd0);

    // R2 reset restores fields
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    doRead(6'h3F, 1, 16'h809F, "R2 word after second reset");
    check("R2 lowPwrRef after reset", {15'd0, lowPwrRef}, 16'd0);

    repeat (3) @(negedge clk);
    check("R1 all reads returned", 16'(expQ.size()), 16'd0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule